// File: doc/BRIEF.md
# Programmable-Timing External Bus Bridge

This block connects a host to an 8-bit external parallel bus that serves up to eight peripheral devices. For each single access requested by the host, the block drives a 12-bit address, write data where needed, one of eight active-low device selects, and an active-low read or write strobe. For reads it captures the data that the device returns.

How long each access lasts is programmable. Four timing sets each give a strobe length and a recovery length, both counted in clock cycles. A selection table names the timing set for every pair of device select and direction, so a slow device can get long read strobes and short writes while a fast device on another select uses short cycles throughout.

The device select number comes from one of two sources. It can come from a control register, in which case the full request address goes onto the bus. It can also come from host address bits 9:7 (memory-mapped mode), in which case host bits 6:0 form the low bus address and a register supplies the upper five bits.

Top module: `ext_bus_bridge`

## Requirements
- R1: Configuration addresses 0 to 3 hold timing sets 0 to 3. Bits [7:4] are the strobe length and bits [3:0] the recovery length, both in clock cycles. A strobe length of 0 behaves as 1 cycle.
- R2: Configuration addresses 4 to 7 hold the selection entries for device select pairs (0,1), (2,3), (4,5) and (6,7). Within each byte, bits [1:0] give the read set and bits [3:2] the write set of the even select, and bits [5:4] and [7:6] give the same for the odd select.
- R3: An access accepted on a clock edge first spends one setup cycle, with select and address driven and both strobes high. The selected strobe is then low for the strobe length, and both strobes are then high for the recovery length while the select stays low. `busy` is high from the setup cycle through the last recovery cycle. Read and write strobes are never low together.
- R4: The eight `bus_cs_n` outputs decode a 3-bit select number. During `busy` exactly one of them is low, and at other times all of them are high.
- R5: Configuration address 8 holds the register select number in bits [2:0] and the source bit in bit 7. When the source bit is 0, the register field chooses the device and `bus_addr` equals `req_addr`.
- R6: When the source bit is 1, `req_addr[9:7]` chooses the device. `bus_addr[6:0]` is `req_addr[6:0]`, and `bus_addr[11:7]` comes from bits [4:0] of configuration address 9. `req_addr[11:10]` has no effect.
- R7: For a read, `bus_data_i` is sampled on the edge that ends the last strobe cycle. `rd_data` holds that value, and `rd_valid` is high for exactly the following cycle.
- R8: `bus_data_oe` is high only during write accesses, from the setup cycle through the last recovery cycle, with `bus_data_o` equal to the request's write data. It is low during reads and while free.
- R9: A request made while `busy` is high is ignored. Timing, select and address are fixed when an access is accepted, so configuration writes during an access do not affect that access.
- R10: After reset, every timing set reads as strobe 15 and recovery 15, every selection entry chooses set 0, the register select is 0 with source 0, and all strobes and selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| req | input | 1 | Access request, taken when not busy |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_addr | input | 12 | Host address of the access |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rd_data | output | 8 | Last captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| bus_addr | output | 12 | External address lines |
| bus_data_o | output | 8 | External data, outgoing |
| bus_data_oe | output | 1 | External data driver enable |
| bus_data_i | input | 8 | External data, incoming |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 8 | Device selects, active low |

## Verification
The bench checks the off-by-one edges of the phase counters: a strobe field of zero must still give one strobe cycle, and a recovery length of zero must leave no extra busy cycle while `rd_valid` still appears on the free cycle. A counter that is wrong by one stretches or shortens the strobe, and the per-cycle comparison catches that. The bench also checks the selection table with the read and write slots of an even and an odd select all different, so swapped slot positions show up as wrong strobe lengths. Memory-mapped mode is driven with high host address bits set, which exposes a design that leaks them onto the bus. Requests and configuration writes are issued during a running access; a bridge that restarts or re-reads its timing would shift the strobe or move the address.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [1:0] {
    PH_FREE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  // Strobe length actually used: a zero field still gives one cycle.
  function automatic int unsigned strobe_len(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

  // Load value of a down-counter that runs for len cycles (len >= 1).
  function automatic int unsigned count_load(input int unsigned len);
    return len - 1;
  endfunction

endpackage

// File: rtl/bb_cfg_regs.sv
module bb_cfg_regs #(
  parameter int N_SETS = 4,
  parameter int TW     = 4,
  parameter int CS_N   = 8,
  parameter int CSW    = 3,
  parameter int SETW   = 2,
  parameter int HIW    = 5,
  parameter int CFG_AW = 4,
  parameter int DW     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [DW-1:0]                 cfg_wdata,
  output logic [N_SETS-1:0][TW-1:0]     set_act,
  output logic [N_SETS-1:0][TW-1:0]     set_idle,
  output logic [CS_N-1:0][SETW-1:0]     sel_rd,
  output logic [CS_N-1:0][SETW-1:0]     sel_wr,
  output logic [CSW-1:0]                ctrl_cs,
  output logic                          ctrl_src,
  output logic [HIW-1:0]                ctrl_hi
);

  localparam int N_PAIRS   = CS_N / 2;
  localparam int PAIR_BASE = N_SETS;
  localparam int CTRL_ADDR = N_SETS + N_PAIRS;
  localparam int HI_ADDR   = CTRL_ADDR + 1;

  // Timing sets: upper half of the byte is strobe length, lower half recovery.
  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic [TW-1:0] act_r;
    logic [TW-1:0] idl_r;
    logic          hit;
    assign hit = cfg_we && (cfg_addr == CFG_AW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r <= '1;
        idl_r <= '1;
      end else if (hit) begin
        act_r <= cfg_wdata[2*TW-1:TW];
        idl_r <= cfg_wdata[TW-1:0];
      end
    end
    assign set_act[s]  = act_r;
    assign set_idle[s] = idl_r;
  end

  // Selection bytes, one per pair of device selects.
  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    logic [DW-1:0] pair_r;
    logic          hit;
    assign hit = cfg_we && (cfg_addr == CFG_AW'(PAIR_BASE + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_r <= '0;
      else if (hit) pair_r <= cfg_wdata;
    end
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign sel_rd[2*k+h] = pair_r[(2*h)*SETW   +: SETW];
      assign sel_wr[2*k+h] = pair_r[(2*h+1)*SETW +: SETW];
    end
  end

  logic ctrl_hit, hi_hit;
  assign ctrl_hit = cfg_we && (cfg_addr == CFG_AW'(CTRL_ADDR));
  assign hi_hit   = cfg_we && (cfg_addr == CFG_AW'(HI_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_cs  <= '0;
      ctrl_src <= 1'b0;
      ctrl_hi  <= '0;
    end else begin
      if (ctrl_hit) begin
        ctrl_cs  <= cfg_wdata[CSW-1:0];
        ctrl_src <= cfg_wdata[DW-1];
      end
      if (hi_hit) ctrl_hi <= cfg_wdata[HIW-1:0];
    end
  end

endmodule

// File: rtl/bb_cs_demux.sv
module bb_cs_demux #(
  parameter int CS_N = 8,
  parameter int CSW  = 3
) (
  input  logic            en,
  input  logic [CSW-1:0]  num,
  output logic [CS_N-1:0] cs_n
);

  for (genvar i = 0; i < CS_N; i++) begin : g_line
    assign cs_n[i] = ~(en && (num == CSW'(i)));
  end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DW     = 8,
  parameter int N_SETS = 4,
  parameter int TW     = 4,
  parameter int CS_N   = 8,
  parameter int CSW    = 3,
  parameter int SETW   = 2,
  parameter int MAP_LO = 7,
  parameter int HIW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  input  logic [N_SETS-1:0][TW-1:0] set_act,
  input  logic [N_SETS-1:0][TW-1:0] set_idle,
  input  logic [CS_N-1:0][SETW-1:0] sel_rd,
  input  logic [CS_N-1:0][SETW-1:0] sel_wr,
  input  logic [CSW-1:0]            ctrl_cs,
  input  logic                      ctrl_src,
  input  logic [HIW-1:0]            ctrl_hi,
  input  logic [DW-1:0]             bus_data_i,
  output logic                      busy,
  output logic                      cs_en,
  output logic [CSW-1:0]            cs_num,
  output logic [AW-1:0]             bus_addr,
  output logic [DW-1:0]             bus_data_o,
  output logic                      bus_data_oe,
  output logic                      bus_rd_n,
  output logic                      bus_wr_n,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_valid
);

  phase_t         phase;
  logic [TW-1:0]  cnt;
  logic [TW-1:0]  idle_q;
  logic           is_wr;
  logic [CSW-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  rdata_q;
  logic           rvalid_q;

  // Request decode: select source, bus address and timing set.
  logic [CSW-1:0]  cs_pick;
  logic [AW-1:0]   addr_pick;
  logic [SETW-1:0] set_pick;
  logic [TW-1:0]   act_load;
  logic [TW-1:0]   idle_pick;

  always_comb begin
    cs_pick   = ctrl_src ? req_addr[MAP_LO +: CSW] : ctrl_cs;
    addr_pick = ctrl_src ? {ctrl_hi, req_addr[MAP_LO-1:0]} : req_addr;
    set_pick  = req_write ? sel_wr[cs_pick] : sel_rd[cs_pick];
    act_load  = TW'(count_load(strobe_len(32'(set_act[set_pick]))));
    idle_pick = set_idle[set_pick];
  end

  // Named events for the sequencer and its assertions.
  logic accept, strobe_last, recover_last, read_capture;
  assign accept       = req && (phase == PH_FREE);
  assign strobe_last  = (phase == PH_STROBE) && (cnt == '0);
  assign recover_last = (phase == PH_RECOVER) && (cnt == '0);
  assign read_capture = strobe_last && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_FREE;
      cnt      <= '0;
      idle_q   <= '0;
      is_wr    <= 1'b0;
      cs_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (phase)
        PH_FREE: begin
          if (accept) begin
            is_wr   <= req_write;
            cs_q    <= cs_pick;
            addr_q  <= addr_pick;
            wdata_q <= req_wdata;
            cnt     <= act_load;
            idle_q  <= idle_pick;
            phase   <= PH_SETUP;
          end
        end
        PH_SETUP: phase <= PH_STROBE;
        PH_STROBE: begin
          if (strobe_last) begin
            if (read_capture) begin
              rdata_q  <= bus_data_i;
              rvalid_q <= 1'b1;
            end
            if (idle_q == '0) begin
              phase <= PH_FREE;
            end else begin
              phase <= PH_RECOVER;
              cnt   <= TW'(count_load(32'(idle_q)));
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOVER: begin
          if (recover_last) phase <= PH_FREE;
          else              cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_FREE;
      endcase
    end
  end

  assign busy        = (phase != PH_FREE);
  assign cs_en       = busy;
  assign cs_num      = cs_q;
  assign bus_addr    = addr_q;
  assign bus_data_o  = wdata_q;
  assign bus_data_oe = busy && is_wr;
  assign bus_rd_n    = !((phase == PH_STROBE) && !is_wr);
  assign bus_wr_n    = !((phase == PH_STROBE) && is_wr);
  assign rd_data     = rdata_q;
  assign rd_valid    = rvalid_q;

  // R9: an ignored request leaves the latched address and select alone.
  a_r9_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(bus_addr) && $stable(cs_num)));

  // R3: the two strobes never overlap.
  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R8: the data driver is never on while a read strobe is low.
  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_data_oe);

  // R3: the strobe never starts in the cycle right after acceptance.
  a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bus_rd_n && bus_wr_n));

endmodule

// File: rtl/ext_bus_bridge.sv
module ext_bus_bridge #(
  parameter int AW     = 12,
  parameter int DW     = 8,
  parameter int CS_N   = 8,
  parameter int N_SETS = 4,
  parameter int TW     = 4,
  parameter int MAP_LO = 7,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              req,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_data_oe,
  input  logic [DW-1:0]     bus_data_i,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [CS_N-1:0]   bus_cs_n
);

  localparam int CSW  = $clog2(CS_N);
  localparam int SETW = $clog2(N_SETS);
  localparam int HIW  = AW - MAP_LO;

  logic [N_SETS-1:0][TW-1:0] set_act, set_idle;
  logic [CS_N-1:0][SETW-1:0] sel_rd, sel_wr;
  logic [CSW-1:0]            ctrl_cs, cs_num;
  logic                      ctrl_src, cs_en;
  logic [HIW-1:0]            ctrl_hi;

  bb_cfg_regs #(
    .N_SETS(N_SETS), .TW(TW), .CS_N(CS_N), .CSW(CSW), .SETW(SETW),
    .HIW(HIW), .CFG_AW(CFG_AW), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .set_act(set_act), .set_idle(set_idle),
    .sel_rd(sel_rd), .sel_wr(sel_wr), .ctrl_cs(ctrl_cs),
    .ctrl_src(ctrl_src), .ctrl_hi(ctrl_hi)
  );

  bb_seq #(
    .AW(AW), .DW(DW), .N_SETS(N_SETS), .TW(TW), .CS_N(CS_N), .CSW(CSW),
    .SETW(SETW), .MAP_LO(MAP_LO), .HIW(HIW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .set_act(set_act),
    .set_idle(set_idle), .sel_rd(sel_rd), .sel_wr(sel_wr),
    .ctrl_cs(ctrl_cs), .ctrl_src(ctrl_src), .ctrl_hi(ctrl_hi),
    .bus_data_i(bus_data_i), .busy(busy), .cs_en(cs_en), .cs_num(cs_num),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o),
    .bus_data_oe(bus_data_oe), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  bb_cs_demux #(.CS_N(CS_N), .CSW(CSW)) u_demux (
    .en(cs_en), .num(cs_num), .cs_n(bus_cs_n)
  );

  // R4: exactly one select low while busy, none otherwise.
  a_r4_one_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~bus_cs_n) == 1));
  a_r4_no_select_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs_n == '1));

  // R3: a strobe only falls after a cycle in which a select was already low.
  a_r3_select_leads_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(bus_cs_n != '1));

  // R7: the read-valid pulse follows the end of a read strobe.
  a_r7_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(bus_rd_n));

endmodule

// File: tb/ext_bus_bridge_tb.sv
module ext_bus_bridge_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        req, req_write;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, rd_valid, bus_data_oe, bus_rd_n, bus_wr_n;
  logic [7:0]  rd_data, bus_data_o, bus_data_i, bus_cs_n;
  logic [11:0] bus_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .bus_addr(bus_addr),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_cs_n(bus_cs_n)
  );

  typedef struct {
    logic        busy;
    logic [7:0]  cs_n;
    logic        rd_n;
    logic        wr_n;
    logic        oe;
    logic [7:0]  dout;
    logic [11:0] addr;
    logic        rvalid;
    logic [7:0]  rdata;
    string       ttag;
    string       atag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   last_busy = 0;
  string cur_ttag = "R3";
  string cur_atag = "R5";

  // Behavioural copy of the programmed state.
  int m_act[4], m_idle[4], m_rsel[8], m_wsel[8];
  int m_cs = 0, m_src = 0, m_hi = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, cyc, got, exp);
    end
  endtask

  function automatic exp_t mk(input string tt, input string at);
    exp_t e;
    e.busy = 1'b0; e.cs_n = 8'hFF; e.rd_n = 1'b1; e.wr_n = 1'b1;
    e.oe = 1'b0; e.dout = '0; e.addr = '0; e.rvalid = 1'b0; e.rdata = '0;
    e.ttag = tt; e.atag = at;
    return e;
  endfunction

  task automatic push_access();
    int cs, bset, act, idl;
    logic [11:0] ba;
    exp_t e;
    cs  = (m_src != 0) ? int'(req_addr[9:7]) : m_cs;
    ba  = (m_src != 0) ? {m_hi[4:0], req_addr[6:0]} : req_addr;
    bset = req_write ? m_wsel[cs] : m_rsel[cs];
    act = (m_act[bset] == 0) ? 1 : m_act[bset];
    idl = m_idle[bset];
    e = mk(cur_ttag, cur_atag);
    e.busy = 1'b1; e.cs_n = ~(8'd1 << cs); e.addr = ba;
    e.oe = req_write; e.dout = req_wdata;
    q.push_back(e);
    for (int i = 0; i < act; i++) begin
      exp_t s = e;
      s.rd_n = req_write; s.wr_n = !req_write;
      q.push_back(s);
    end
    for (int i = 0; i < idl; i++) begin
      exp_t r = e;
      if (i == 0 && !req_write) begin r.rvalid = 1'b1; r.rdata = bus_data_i; end
      q.push_back(r);
    end
    if (idl == 0 && !req_write) begin
      exp_t f = mk("R7", cur_atag);
      f.rvalid = 1'b1; f.rdata = bus_data_i;
      q.push_back(f);
    end
  endtask

  task automatic model_cfg();
    int a = int'(cfg_addr);
    int d = int'(cfg_wdata);
    if (a < 4) begin m_act[a] = d >> 4; m_idle[a] = d & 15; end
    else if (a < 8) begin
      m_rsel[2*(a-4)]   = d & 3;
      m_wsel[2*(a-4)]   = (d >> 2) & 3;
      m_rsel[2*(a-4)+1] = (d >> 4) & 3;
      m_wsel[2*(a-4)+1] = (d >> 6) & 3;
    end else if (a == 8) begin m_cs = d & 7; m_src = (d >> 7) & 1; end
    else if (a == 9) m_hi = d & 31;
  endtask

  task automatic tick();
    exp_t e;
    if (req && !last_busy) push_access();
    if (cfg_we) model_cfg();
    @(posedge clk);
    #1;
    cyc++;
    if (q.size() > 0) e = q.pop_front();
    else e = mk("R3", "R5");
    chk(e.ttag, "busy", 32'(busy), 32'(e.busy));
    chk(e.ttag, "rd_n", 32'(bus_rd_n), 32'(e.rd_n));
    chk(e.ttag, "wr_n", 32'(bus_wr_n), 32'(e.wr_n));
    chk("R4", "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
    chk("R8", "oe", 32'(bus_data_oe), 32'(e.oe));
    chk("R7", "rd_valid", 32'(rd_valid), 32'(e.rvalid));
    if (e.busy) chk(e.atag, "addr", 32'(bus_addr), 32'(e.addr));
    if (e.oe) chk("R8", "dout", 32'(bus_data_o), 32'(e.dout));
    if (e.rvalid) chk("R7", "rd_data", 32'(rd_data), 32'(e.rdata));
    last_busy = e.busy;
  endtask

  task automatic drain();
    while (q.size() > 0 || last_busy) tick();
    tick();
  endtask

  task automatic cfg_write(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input int addr, input int wd, input int rdv,
                        input string tt, input string at);
    cur_ttag = tt; cur_atag = at;
    bus_data_i = 8'(rdv);
    req = 1'b1; req_write = wr; req_addr = 12'(addr); req_wdata = 8'(wd);
    tick();
    req = 1'b0;
    drain();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_act[i] = 15; m_idle[i] = 15; end
    for (int i = 0; i < 8; i++) begin m_rsel[i] = 0; m_wsel[i] = 0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    bus_data_i = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs idle during reset.
    chk("R10", "cs_n in reset", 32'(bus_cs_n), 32'hFF);
    chk("R10", "strobes in reset", 32'({bus_rd_n, bus_wr_n}), 32'h3);
    rst_n = 1'b1;
    tick(); tick();

    // R10: defaults give 15-cycle strobe, 15-cycle recovery, select 0.
    access(0, 12'h123, 0, 8'hA5, "R10", "R5");
    access(1, 12'hFED, 8'h3C, 0, "R10", "R5");

    // R1: program the four timing sets (set1 strobe field 0 acts as 1).
    cfg_write(0, 8'h21);
    cfg_write(1, 8'h00);
    cfg_write(2, 8'h32);
    cfg_write(3, 8'h13);
    // R2: cs0 rd=1 wr=2, cs1 rd=3 wr=0; cs7 rd=2 wr=3.
    cfg_write(4, 8'h39);
    cfg_write(7, 8'hE0);
    // R5: register select 1, source 0.
    cfg_write(8, 8'h01);
    access(1, 12'h456, 8'h77, 0, "R2", "R5");
    access(0, 12'h0AB, 0, 8'h5E, "R2", "R5");
    cfg_write(8, 8'h00);
    access(1, 12'h800, 8'h81, 0, "R1", "R5");
    access(0, 12'h7FF, 0, 8'hC3, "R1", "R5");

    // R6: memory-mapped mode, high host bits set to check they are dropped.
    cfg_write(8, 8'h80);
    cfg_write(9, 8'h15);
    access(0, 12'hFDA, 0, 8'h96, "R2", "R6");
    access(1, 12'hCDA, 8'h42, 0, "R2", "R6");
    access(0, 12'h0A5, 0, 8'h11, "R1", "R6");

    // R9: requests and a timing rewrite during a running access.
    cfg_write(8, 8'h00);
    cur_ttag = "R9"; cur_atag = "R9";
    bus_data_i = 8'h6D;
    req = 1'b1; req_write = 1'b0; req_addr = 12'h321;
    tick();
    req = 1'b0;
    tick();
    req = 1'b1; req_write = 1'b1; req_addr = 12'h999; req_wdata = 8'hEE;
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 8'hF0;
    tick();
    cfg_we = 1'b0;
    tick();
    req = 1'b0;
    drain();
    cfg_write(1, 8'h00);

    // R3: back-to-back requests held high, cs1 write uses set 0.
    cfg_write(8, 8'h01);
    cur_ttag = "R3"; cur_atag = "R5";
    req = 1'b1; req_write = 1'b1; req_addr = 12'h00F; req_wdata = 8'h5A;
    repeat (14) tick();
    req = 1'b0;
    drain();

    finish_run();
  end

endmodule